// File: doc/BRIEF.md
# Thread Store Buffer and Load-Miss Controller

This block orders the memory operations of a single hardware thread in an in-order core. Stores are parked in a small circular store buffer and drained to a shared L2 cache one at a time: a store leaves the buffer only after the L2 has acknowledged the previous one and finished updating the cache. Loads are sent down one of three paths. A load that hits in the L1 and matches no buffered store writes back at once. A load that misses in the L1 goes to a one-entry load-miss queue and reads the L2. A load whose address matches a buffered store is a read-after-write. It also goes through the miss queue, but it takes its data from the youngest matching store-buffer entry and not from the L2.

When a load misses or forwards, the thread is flushed. The stall output stays high, and no request is accepted, until that load has written back. Stores keep draining to the L2 during the stall. The decode side presents one request per cycle with a valid/ready handshake. On a load, the request data carries the L1 read data, and a flag tells whether the L1 hit.

Top module: `thrd_memord`

## Requirements
- R1: After reset, stall, sb_full, l2_st_req, l2_ld_req and wb_valid are all 0, and req_ready is 1 while req_is_store is 0.
- R2: The store buffer holds DEPTH (default 4) stores. While it holds DEPTH, sb_full is 1 and req_ready is 0 for a store request. A load request is still accepted while the buffer is full.
- R3: Buffered stores are offered to the L2 in arrival order. l2_st_req is high for exactly one cycle per store, carrying that store's address and data. No second l2_st_req appears until l2_st_ack has been seen for the previous one. The next store may be offered in the cycle after the ack.
- R4: A load accepted with req_l1_hit=1 and no buffered store at its address produces wb_valid=1 with wb_data equal to the request data in the next cycle. It leaves stall at 0 and issues no L2 read.
- R5: A load accepted with req_l1_hit=0 and no buffered store at its address raises stall in the next cycle. In that same cycle it raises l2_ld_req for exactly one cycle, with l2_ld_addr equal to the load address.
- R6: A fill (l2_fill_valid) that arrives while a miss is waiting produces wb_valid=1 with wb_data equal to the fill data in the next cycle. In that same cycle stall returns to 0.
- R7: While stall is 1, req_ready is 0.
- R8: A load whose address equals that of any buffered store takes the forwarding path, whether the store is still waiting or is already offered to the L2, and whatever req_l1_hit says. Stall is 1 for one cycle and no L2 read is issued. In the cycle after that, wb_valid=1 and wb_data holds the data of the youngest buffered store to that address.
- R9: An l2_fill_valid while no miss is waiting, and an l2_st_ack while no store is offered, change nothing. No writeback is produced, and the buffer state is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A memory request is presented |
| req_is_store | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | AW | Request address |
| req_data | input | DW | Store data, or L1 read data for a load |
| req_l1_hit | input | 1 | The load hit in the L1 |
| req_ready | output | 1 | The request is accepted at this edge |
| sb_full | output | 1 | The store buffer holds DEPTH entries |
| stall | output | 1 | Hold the thread at the pick stage |
| l2_st_req | output | 1 | One-cycle store write offer to the L2 |
| l2_st_addr | output | AW | Address of the offered store |
| l2_st_data | output | DW | Data of the offered store |
| l2_st_ack | input | 1 | The L2 acknowledged the store and finished updating the cache |
| l2_ld_req | output | 1 | One-cycle L2 read for a missed load |
| l2_ld_addr | output | AW | Address of the L2 read |
| l2_fill_valid | input | 1 | L2 read data is returned |
| l2_fill_data | input | DW | Returned data |
| wb_valid | output | 1 | Load result is written back |
| wb_data | output | DW | Load result |

## Verification
Some rules are checked by the assertions on every cycle:
- a second store is never offered to the L2 while one is unacknowledged;
- a request is never accepted during a stall, and a store is never accepted into a full buffer;
- the cycle after each load sees the right stall and L2-read behaviour for its path.

Other behaviour depends on values and history, and only the bench scenarios show it:
- the order of the store data reaching the L2;
- the selection of the youngest among several matching stores;
- forwarding from a store that is already offered to the L2;
- the absence of effect from stray fills and acks.

The scenarios fill the buffer, forward from it while it is full, and mix loads and stores to a small set of addresses with varied L2 delays.

// File: rtl/thrd_memord_pkg.sv
package thrd_memord_pkg;

  typedef enum logic [1:0] {
    MQ_IDLE  = 2'd0,
    MQ_ISSUE = 2'd1,
    MQ_WAIT  = 2'd2,
    MQ_FWD   = 2'd3
  } mq_state_e;

  typedef enum logic [1:0] {
    LP_NONE = 2'd0,
    LP_HIT  = 2'd1,
    LP_MISS = 2'd2,
    LP_RAW  = 2'd3
  } ld_path_e;

  // A buffered store at the same address overrides the L1 hit flag.
  function automatic ld_path_e pick_path(input logic ld_acc,
                                         input logic sb_match,
                                         input logic l1_hit);
    if (!ld_acc)  return LP_NONE;
    if (sb_match) return LP_RAW;
    if (l1_hit)   return LP_HIT;
    return LP_MISS;
  endfunction

endpackage

// File: rtl/thrd_sb.sv
module thrd_sb #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          ack_i,
  input  logic [AW-1:0] look_addr_i,
  output logic          look_hit_o,
  output logic [DW-1:0] look_data_o,
  output logic          full_o,
  output logic          st_req_o,
  output logic [AW-1:0] st_addr_o,
  output logic [DW-1:0] st_data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] slot_of(input logic [PW-1:0] base,
                                            input int unsigned age);
    int unsigned s;
    s = (32'(base) + age) % 32'(DEPTH);
    return s[PW-1:0];
  endfunction

  logic [AW-1:0]    e_addr [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic [DEPTH-1:0] e_vld;
  logic [PW-1:0]    head, tail;
  logic [CW-1:0]    cnt;
  logic             busy;
  logic             pop;

  assign pop       = busy && ack_i;
  assign full_o    = (cnt == CW'(DEPTH));
  assign st_req_o  = !busy && (cnt != '0);
  assign st_addr_o = e_addr[head];
  assign st_data_o = e_data[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      e_vld <= '0;
    end else begin
      if (pop) begin
        e_vld[head] <= 1'b0;
        head        <= slot_of(head, 1);
        busy        <= 1'b0;
      end else if (st_req_o) begin
        busy <= 1'b1;
      end
      if (push_i) begin
        e_vld[tail] <= 1'b1;
        tail        <= slot_of(tail, 1);
      end
      unique case ({push_i, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      e_addr[tail] <= push_addr_i;
      e_data[tail] <= push_data_i;
    end
  end

  // Address compare per age position; age 0 is the oldest entry.
  logic [PW-1:0]    age_slot [DEPTH];
  logic [DEPTH-1:0] age_hit;

  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign age_slot[k] = slot_of(head, k);
    assign age_hit[k]  = e_vld[age_slot[k]] &&
                         (e_addr[age_slot[k]] == look_addr_i);
  end

  // The last (youngest) matching position wins.
  always_comb begin
    look_hit_o  = |age_hit;
    look_data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (age_hit[k]) look_data_o = e_data[age_slot[k]];
    end
  end

endmodule

// File: rtl/thrd_lmq.sv
module thrd_lmq
  import thrd_memord_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ld_path_e      path_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic [DW-1:0] fwd_data_i,
  input  logic          fill_valid_i,
  input  logic [DW-1:0] fill_data_i,
  output logic          ld_req_o,
  output logic [AW-1:0] ld_addr_o,
  output logic          wb_valid_o,
  output logic [DW-1:0] wb_data_o,
  output logic          busy_o,
  output logic          waiting_o
);
  mq_state_e     state;
  logic [AW-1:0] q_addr;
  logic [DW-1:0] q_data;

  assign busy_o    = (state != MQ_IDLE);
  assign ld_req_o  = (state == MQ_ISSUE);
  assign waiting_o = (state == MQ_WAIT);
  assign ld_addr_o = q_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= MQ_IDLE;
      q_addr     <= '0;
      q_data     <= '0;
      wb_valid_o <= 1'b0;
      wb_data_o  <= '0;
    end else begin
      wb_valid_o <= 1'b0;
      unique case (state)
        MQ_IDLE: begin
          unique case (path_i)
            LP_HIT: begin
              wb_valid_o <= 1'b1;
              wb_data_o  <= ld_data_i;
            end
            LP_MISS: begin
              q_addr <= ld_addr_i;
              state  <= MQ_ISSUE;
            end
            LP_RAW: begin
              q_data <= fwd_data_i;
              state  <= MQ_FWD;
            end
            default: ;
          endcase
        end
        MQ_ISSUE: state <= MQ_WAIT;
        MQ_WAIT: begin
          if (fill_valid_i) begin
            wb_valid_o <= 1'b1;
            wb_data_o  <= fill_data_i;
            state      <= MQ_IDLE;
          end
        end
        MQ_FWD: begin
          wb_valid_o <= 1'b1;
          wb_data_o  <= q_data;
          state      <= MQ_IDLE;
        end
        default: state <= MQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/thrd_memord.sv
module thrd_memord
  import thrd_memord_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_is_store,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_l1_hit,
  output logic          req_ready,
  output logic          sb_full,
  output logic          stall,
  output logic          l2_st_req,
  output logic [AW-1:0] l2_st_addr,
  output logic [DW-1:0] l2_st_data,
  input  logic          l2_st_ack,
  output logic          l2_ld_req,
  output logic [AW-1:0] l2_ld_addr,
  input  logic          l2_fill_valid,
  input  logic [DW-1:0] l2_fill_data,
  output logic          wb_valid,
  output logic [DW-1:0] wb_data
);
  logic          st_push, ld_acc;
  logic          sb_match;
  logic [DW-1:0] sb_fwd_data;
  ld_path_e      ld_path;

  // Named events for the checker.
  logic ev_ld_hit, ev_ld_miss, ev_ld_raw, mq_wait;

  assign req_ready = !stall && (!req_is_store || !sb_full);
  assign st_push   = req_valid && req_ready && req_is_store;
  assign ld_acc    = req_valid && req_ready && !req_is_store;
  assign ld_path   = pick_path(ld_acc, sb_match, req_l1_hit);

  assign ev_ld_hit  = (ld_path == LP_HIT);
  assign ev_ld_miss = (ld_path == LP_MISS);
  assign ev_ld_raw  = (ld_path == LP_RAW);

  thrd_sb #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sb (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (st_push),
    .push_addr_i (req_addr),
    .push_data_i (req_data),
    .ack_i       (l2_st_ack),
    .look_addr_i (req_addr),
    .look_hit_o  (sb_match),
    .look_data_o (sb_fwd_data),
    .full_o      (sb_full),
    .st_req_o    (l2_st_req),
    .st_addr_o   (l2_st_addr),
    .st_data_o   (l2_st_data)
  );

  thrd_lmq #(.AW(AW), .DW(DW)) u_lmq (
    .clk          (clk),
    .rst_n        (rst_n),
    .path_i       (ld_path),
    .ld_addr_i    (req_addr),
    .ld_data_i    (req_data),
    .fwd_data_i   (sb_fwd_data),
    .fill_valid_i (l2_fill_valid),
    .fill_data_i  (l2_fill_data),
    .ld_req_o     (l2_ld_req),
    .ld_addr_o    (l2_ld_addr),
    .wb_valid_o   (wb_valid),
    .wb_data_o    (wb_data),
    .busy_o       (stall),
    .waiting_o    (mq_wait)
  );

endmodule

// File: rtl/thrd_memord_chk.sv
module thrd_memord_chk (
  input logic clk,
  input logic rst_n,
  input logic req_is_store,
  input logic req_ready,
  input logic sb_full,
  input logic stall,
  input logic l2_st_req,
  input logic l2_st_ack,
  input logic l2_ld_req,
  input logic l2_fill_valid,
  input logic wb_valid,
  input logic ev_ld_hit,
  input logic ev_ld_miss,
  input logic ev_ld_raw,
  input logic mq_wait
);
  // Tracks an unacknowledged store offer, as seen at the ports.
  logic st_out;
  always_ff @(posedge clk) begin
    if (!rst_n)         st_out <= 1'b0;
    else if (l2_st_req) st_out <= 1'b1;
    else if (l2_st_ack) st_out <= 1'b0;
  end

  p_single_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    l2_st_req |-> !st_out);

  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_full && req_is_store) |-> !req_ready);

  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !req_ready);

  p_hit_nostall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ld_hit |=> (wb_valid && !stall && !l2_ld_req));

  p_miss_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ld_miss |=> (stall && l2_ld_req));

  p_fill_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_fill_valid && mq_wait) |=> (wb_valid && !stall));

  p_raw_noread_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ld_raw |=> (stall && !l2_ld_req));

  p_raw_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ld_raw |=> ##1 (wb_valid && !stall));

endmodule

bind thrd_memord thrd_memord_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_is_store  (req_is_store),
  .req_ready     (req_ready),
  .sb_full       (sb_full),
  .stall         (stall),
  .l2_st_req     (l2_st_req),
  .l2_st_ack     (l2_st_ack),
  .l2_ld_req     (l2_ld_req),
  .l2_fill_valid (l2_fill_valid),
  .wb_valid      (wb_valid),
  .ev_ld_hit     (ev_ld_hit),
  .ev_ld_miss    (ev_ld_miss),
  .ev_ld_raw     (ev_ld_raw),
  .mq_wait       (mq_wait)
);

// File: tb/sim_thrd_memord.sv
module sim_thrd_memord;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_is_store = 1'b0, req_l1_hit = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_ready, sb_full, stall;
  logic          l2_st_req, l2_ld_req, wb_valid;
  logic [AW-1:0] l2_st_addr, l2_ld_addr;
  logic [DW-1:0] l2_st_data, wb_data;
  logic          l2_st_ack = 1'b0, l2_fill_valid = 1'b0;
  logic [DW-1:0] l2_fill_data = '0;

  always #4 clk = ~clk;

  thrd_memord #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
    .req_addr(req_addr), .req_data(req_data), .req_l1_hit(req_l1_hit),
    .req_ready(req_ready), .sb_full(sb_full), .stall(stall),
    .l2_st_req(l2_st_req), .l2_st_addr(l2_st_addr), .l2_st_data(l2_st_data),
    .l2_st_ack(l2_st_ack), .l2_ld_req(l2_ld_req), .l2_ld_addr(l2_ld_addr),
    .l2_fill_valid(l2_fill_valid), .l2_fill_data(l2_fill_data),
    .wb_valid(wb_valid), .wb_data(wb_data)
  );

  int n_chk = 0, n_bad = 0;
  int ack_dly = 2, fill_dly = 2;
  bit mon_on = 1'b0, st_out = 1'b0;

  // Scoreboard queues and a shadow of the stores not yet acknowledged.
  logic [AW-1:0] exp_ld_q[$];
  logic [DW-1:0] exp_wb_q[$];
  string         exp_wb_tag[$];
  logic [AW-1:0] exp_sta_q[$], sh_a[$];
  logic [DW-1:0] exp_std_q[$], sh_d[$];

  function automatic logic [DW-1:0] fill_fn(input logic [AW-1:0] a);
    return {a, ~a} ^ 32'h5a5a_0f0f;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Driver: presents one request, predicts its path, pushes expectations.
  task automatic do_req(input bit st, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit hit);
    int found;
    int path;
    @(posedge clk); #1;
    req_valid = 1'b1; req_is_store = st; req_addr = a; req_data = d; req_l1_hit = hit;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    found = -1;
    path = 0;
    if (st) begin
      exp_sta_q.push_back(a); exp_std_q.push_back(d);
    end else begin
      for (int i = 0; i < sh_a.size(); i++) if (sh_a[i] == a) found = i;
      if (found >= 0) begin
        path = 3; exp_wb_q.push_back(sh_d[found]); exp_wb_tag.push_back("R8");
      end else if (hit) begin
        path = 1; exp_wb_q.push_back(d); exp_wb_tag.push_back("R4");
      end else begin
        path = 2; exp_ld_q.push_back(a);
        exp_wb_q.push_back(fill_fn(a)); exp_wb_tag.push_back("R6");
      end
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (st) begin sh_a.push_back(a); sh_d.push_back(d); end
    @(negedge clk);
    if (path == 1) chk("R4 stall after hit", stall, 0);
    if (path == 2) begin
      chk("R5 stall after miss", stall, 1);
      chk("R5 l2_ld_req after miss", l2_ld_req, 1);
      while (stall) @(negedge clk);
      chk("R6 wb_valid when stall drops", wb_valid, 1);
    end
    if (path == 3) begin
      chk("R8 stall after raw", stall, 1);
      chk("R8 no l2 read on raw", l2_ld_req, 0);
      @(negedge clk);
      chk("R8 stall one cycle", stall, 0);
    end
  endtask

  // Monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (wb_valid) begin
          if (exp_wb_q.size() == 0) chk("R9 unexpected writeback", 1, 0);
          else chk({exp_wb_tag.pop_front(), " wb_data"}, wb_data, exp_wb_q.pop_front());
        end
        if (l2_ld_req) begin
          if (exp_ld_q.size() == 0) chk("R5 unexpected l2_ld_req", 1, 0);
          else chk("R5 l2_ld_addr", l2_ld_addr, exp_ld_q.pop_front());
        end
        if (l2_st_req) begin
          chk("R3 offer while outstanding", st_out, 0);
          if (exp_sta_q.size() == 0) chk("R3 unexpected l2_st_req", 1, 0);
          else begin
            chk("R3 l2_st_addr", l2_st_addr, exp_sta_q.pop_front());
            chk("R3 l2_st_data", l2_st_data, exp_std_q.pop_front());
          end
          st_out = 1'b1;
        end
        if (l2_st_ack) st_out = 1'b0;
        if (stall) chk("R7 req_ready during stall", req_ready, 0);
      end
    end
  end

  // L2 store acknowledger.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && l2_st_req) begin
        repeat (ack_dly) @(posedge clk);
        #1 l2_st_ack = 1'b1;
        @(posedge clk);
        #1 l2_st_ack = 1'b0;
        void'(sh_a.pop_front()); void'(sh_d.pop_front());
      end
    end
  end

  // L2 read responder.
  initial begin
    logic [AW-1:0] fa;
    forever begin
      @(negedge clk);
      if (mon_on && l2_ld_req) begin
        fa = l2_ld_addr;
        repeat (fill_dly) @(posedge clk);
        #1 l2_fill_valid = 1'b1; l2_fill_data = fill_fn(fa);
        @(posedge clk);
        #1 l2_fill_valid = 1'b0;
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 stall in reset", stall, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stall", stall, 0);
    chk("R1 sb_full", sb_full, 0);
    chk("R1 l2_st_req", l2_st_req, 0);
    chk("R1 l2_ld_req", l2_ld_req, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    mon_on = 1'b1;

    // R9: stray fill and ack while idle.
    @(posedge clk); #1;
    l2_fill_valid = 1'b1; l2_fill_data = 32'hdead_beef; l2_st_ack = 1'b1;
    @(posedge clk); #1;
    l2_fill_valid = 1'b0; l2_st_ack = 1'b0;
    @(negedge clk);
    chk("R9 wb_valid after stray fill", wb_valid, 0);
    chk("R9 stall after stray fill", stall, 0);
    chk("R9 l2_st_req after stray ack", l2_st_req, 0);
    chk("R9 sb_full after stray ack", sb_full, 0);

    // R4: hits with no buffered store.
    do_req(0, 16'h0010, 32'h1111_0000, 1);
    do_req(0, 16'h0011, 32'h2222_0000, 1);
    do_req(0, 16'h0012, 32'h3333_0000, 1);

    // R2/R3: fill the buffer while the first ack is held back.
    ack_dly = 40;
    for (int i = 0; i < DEPTH; i++) do_req(1, 16'h0100 + 16'(i), 32'hA000_0000 + 32'(i), 0);
    @(negedge clk);
    chk("R2 sb_full with DEPTH stores", sb_full, 1);
    @(posedge clk); #1;
    req_valid = 1'b1; req_is_store = 1'b1; req_addr = 16'h0105;
    @(negedge clk);
    chk("R2 store refused when full", req_ready, 0);
    @(posedge clk); #1 req_valid = 1'b0;
    do_req(0, 16'h0200, 32'h4444_0000, 1);          // R2: load accepted while full
    do_req(0, 16'h0100, 32'hFFFF_FFFF, 1);          // R8: forward from in-flight store
    do_req(0, 16'h0102, 32'h0, 0);                  // R8: forward regardless of miss flag
    do_req(1, 16'h0102, 32'hB000_0002, 0);          // waits for space
    do_req(0, 16'h0102, 32'h0, 1);                  // R8: youngest match wins
    ack_dly = 1;

    // R5/R6: misses with different fill delays.
    fill_dly = 1; do_req(0, 16'h0300, 32'h0, 0);
    fill_dly = 4; do_req(0, 16'h0301, 32'h0, 0);

    // Mixed traffic over a small address set.
    for (int i = 0; i < 80; i++) begin
      ack_dly  = $urandom_range(1, 5);
      fill_dly = $urandom_range(1, 4);
      do_req(1'($urandom_range(0, 1)), 16'h0040 + 16'($urandom_range(0, 5)),
             $urandom, 1'($urandom_range(0, 1)));
    end

    for (int i = 0; i < 400; i++) begin
      if (exp_wb_q.size() != 0 || exp_sta_q.size() != 0 || sh_a.size() != 0 || st_out)
        @(negedge clk);
    end
    chk("R3 all stores offered", exp_sta_q.size(), 0);
    chk("R3 all stores acknowledged", sh_a.size(), 0);
    chk("R6 all writebacks seen", exp_wb_q.size(), 0);
    chk("R1 stall at end", stall, 0);
    finish_run();
  end

endmodule